// File: doc/BRIEF.md
# JTAG Flash Data Scan Register

This block is a test-port data register that lets a debug host move 16-bit words into and out of on-chip flash one scan at a time. It is active when the instruction decoder raises either the read select or the write select. The TAP controller supplies the capture, shift and update strobes, which are synchronous to TCK. On the flash side the block issues requests on a hold-until-acknowledge interface. A request carries an address and, for a write, the write data. The acknowledge returns read data and an error bit.

A handshake bit inside the 18-bit chain paces the transfers. In read mode, the host loads a start address, and the block fetches that word ahead of time. Each capture that finds a word ready hands the word to the host, steps the address by two and fetches the next word. In write mode, the host shifts in a word with the handshake bit set. The block writes the word to flash, then reads the same location back and compares it with what was written. A mismatch is reported in the chain and also in a program-error flag that stays set until reset.

Top module: `jtag_flash_dr`

## Requirements
- R1: The chain is 18 bits: bits 15:0 hold data, bit 16 is the valid flag, bit 17 is the error flag. Bits enter at `tdi` and leave at `tdo` LSB first, one bit per rising TCK edge while `shift_dr` is high. `tdo` shows chain bit 0 and changes only on the falling TCK edge.
- R2: A capture with either select high loads {error, valid, read buffer} into the chain, then clears the internal valid flag.
- R3: In read mode, a capture that sees valid set steps the address by 2 and starts a flash read there. When that read is acknowledged, the word goes into the read buffer, the flash error input goes into the error flag, and valid sets.
- R4: In read mode, a capture that sees valid clear leaves the address unchanged and starts no flash access.
- R5: In write mode, an update with valid clear, chain bit 16 set and no access in progress writes chain bits 15:0 to the current address.
- R6: In write mode, an update is ignored when the valid flag is still set or when chain bit 16 is clear. No request is made and flash is not changed.
- R7: `busy` is high from the edge of the update that starts a write until the edge that takes in the write acknowledge.
- R8: After a write is acknowledged, the block reads the same address back into the read buffer. The error flag becomes the OR of any flash error and (read-back differs from written word). Valid then sets and the address steps by 2.
- R9: `prog_err` sets on a read-back mismatch and stays set until `trst_n` is asserted.
- R10: A pulse on `addr_load` while no access is in progress loads `addr_in`, clears valid and fetches the word at that address.
- R11: While in reset and after it, `busy`, `prog_err`, `fl_req` and `tdo` are 0, and the first capture returns valid 0.
- R12: When a capture and a read acknowledge arrive in the same cycle, the capture returns valid 0 and the acknowledged word is kept with valid set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous reset, active low |
| sel_rd | input | 1 | Read instruction selected |
| sel_wr | input | 1 | Write instruction selected |
| capture_dr | input | 1 | TAP capture strobe |
| shift_dr | input | 1 | TAP shift strobe |
| update_dr | input | 1 | TAP update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, falling-edge timed |
| addr_load | input | 1 | Load start address and prefetch |
| addr_in | input | AW | Start address |
| fl_req | output | 1 | Flash request, held until acknowledge |
| fl_we | output | 1 | Request is a write |
| fl_addr | output | AW | Flash byte address |
| fl_wdata | output | DW | Flash write data |
| fl_rdata | input | DW | Flash read data, valid with acknowledge |
| fl_ack | input | 1 | Flash access done |
| fl_err | input | 1 | Flash access error, valid with acknowledge |
| busy | output | 1 | Flash write in progress |
| prog_err | output | 1 | Sticky read-back mismatch flag |

## Verification
A host capture and the completion of a prefetch read can land in the same TCK cycle. In that cycle, clearing valid and setting valid compete for the same flag. The bench watches the flash model's acknowledge and raises the capture strobe so that both reach the block on the same edge. The result is judged at the ports in two ways. The scanned-out valid bit must be 0. The next capture must return the prefetched word with valid set, which also shows the address advanced only once.

// File: rtl/jtag_flash_dr.sv
module jtag_flash_dr #(
  parameter int DW   = 16,
  parameter int AW   = 16,
  parameter int STEP = 2
) (
  input  logic          tck,
  input  logic          trst_n,
  input  logic          sel_rd,
  input  logic          sel_wr,
  input  logic          capture_dr,
  input  logic          shift_dr,
  input  logic          update_dr,
  input  logic          tdi,
  output logic          tdo,
  input  logic          addr_load,
  input  logic [AW-1:0] addr_in,
  output logic          fl_req,
  output logic          fl_we,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  input  logic [DW-1:0] fl_rdata,
  input  logic          fl_ack,
  input  logic          fl_err,
  output logic          busy,
  output logic          prog_err
);
  localparam int CW = DW + 2;
  localparam logic [AW-1:0] INC = AW'(STEP);

  typedef enum logic [1:0] {IDLE, RD, WR, VR} st_t;
  st_t st;

  logic [CW-1:0] sr;
  logic [DW-1:0] rbuf;
  logic          vld, err;

  wire idle    = (st == IDLE);
  wire cap     = capture_dr & (sel_rd | sel_wr);
  wire rd_next = cap & sel_rd & vld & idle & ~addr_load;
  wire wr_go   = update_dr & sel_wr & ~vld & sr[DW] & idle & ~addr_load;
  wire mism    = (fl_rdata != fl_wdata);

  assign fl_req = ~idle;
  assign fl_we  = (st == WR);
  assign busy   = (st == WR);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      st       <= IDLE;
      sr       <= '0;
      rbuf     <= '0;
      vld      <= 1'b0;
      err      <= 1'b0;
      fl_addr  <= '0;
      fl_wdata <= '0;
      prog_err <= 1'b0;
    end else begin
      if (cap)
        sr <= {err, vld, rbuf};
      else if (shift_dr & (sel_rd | sel_wr))
        sr <= {tdi, sr[CW-1:1]};
      if (cap) vld <= 1'b0;
      case (st)
        IDLE: begin
          if (addr_load) begin
            fl_addr <= addr_in;
            vld     <= 1'b0;
            st      <= RD;
          end else if (rd_next) begin
            fl_addr <= fl_addr + INC;
            st      <= RD;
          end else if (wr_go) begin
            fl_wdata <= sr[DW-1:0];
            st       <= WR;
          end
        end
        RD: if (fl_ack) begin
          rbuf <= fl_rdata;
          err  <= fl_err;
          vld  <= 1'b1;
          st   <= IDLE;
        end
        WR: if (fl_ack) begin
          err <= fl_err;
          st  <= VR;
        end
        VR: if (fl_ack) begin
          rbuf     <= fl_rdata;
          err      <= err | fl_err | mism;
          prog_err <= prog_err | mism;
          vld      <= 1'b1;
          fl_addr  <= fl_addr + INC;
          st       <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) tdo <= 1'b0;
    else         tdo <= sr[0];
  end

  a_r5_write_starts: assert property (@(posedge tck) disable iff (!trst_n)
    wr_go |=> busy && fl_req && fl_wdata == $past(sr[DW-1:0]));

  a_r7_busy_ends_on_ack: assert property (@(posedge tck) disable iff (!trst_n)
    (busy && fl_ack) |=> !busy);

  a_r3_addr_step: assert property (@(posedge tck) disable iff (!trst_n)
    rd_next |=> fl_addr == $past(fl_addr) + INC && fl_req && !fl_we);

  a_r9_sticky: assert property (@(posedge tck) disable iff (!trst_n)
    prog_err |=> prog_err);

  a_r2_capture_clears: assert property (@(posedge tck) disable iff (!trst_n)
    (cap && !fl_ack) |=> !vld);

  a_r4_no_access_on_empty: assert property (@(posedge tck) disable iff (!trst_n)
    (cap && sel_rd && !vld && idle && !addr_load) |=> !fl_req && $stable(fl_addr));

  a_r1_req_held: assert property (@(posedge tck) disable iff (!trst_n)
    (fl_req && !fl_ack) |=> fl_req && $stable(fl_addr) && $stable(fl_we));
endmodule

// File: tb/jtag_flash_dr_bench.sv
`timescale 1ns/1ps
module jtag_flash_dr_bench;
  logic tck = 0, trst_n = 0;
  logic sel_rd = 0, sel_wr = 0, capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
  logic addr_load = 0;
  logic [15:0] addr_in = 0;
  logic tdo, fl_req, fl_we, busy, prog_err;
  logic [15:0] fl_addr, fl_wdata;
  logic [15:0] fl_rdata = 0;
  logic fl_ack = 0, fl_err = 0;

  always #2.5 tck = ~tck;

  jtag_flash_dr u_jtag_flash_dr (
    .tck(tck), .trst_n(trst_n), .sel_rd(sel_rd), .sel_wr(sel_wr),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .tdo(tdo), .addr_load(addr_load), .addr_in(addr_in),
    .fl_req(fl_req), .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_rdata(fl_rdata), .fl_ack(fl_ack), .fl_err(fl_err),
    .busy(busy), .prog_err(prog_err));

  int total = 0, bad = 0, lat = 3, cnt = 0;
  logic [15:0] xmask = 0;
  logic inj_err = 0;
  logic [15:0] mem [256];

  function automatic logic [15:0] initv(input logic [15:0] a);
    return 16'h3C00 ^ {a[8:1], a[8:1]};
  endfunction

  initial for (int i = 0; i < 256; i++) mem[i] = initv(16'(i * 2));

  always @(posedge tck) begin
    if (!trst_n) begin
      fl_ack <= 0; cnt <= 0;
    end else if (fl_req && !fl_ack) begin
      if (cnt >= lat - 1) begin
        fl_ack <= 1; cnt <= 0; fl_err <= inj_err;
        if (fl_we) mem[fl_addr[8:1]] <= fl_wdata;
        else fl_rdata <= mem[fl_addr[8:1]] ^ xmask;
      end else cnt <= cnt + 1;
    end else fl_ack <= 0;
  end

  localparam logic [15:0] VEC [6] = '{16'hFFFF, 16'h0000, 16'hA5A5, 16'h5A5A, 16'h0001, 16'h8000};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge tck);
    @(negedge tck); #1;
  endtask

  task automatic cap_pulse();
    capture_dr = 1; tick(1); capture_dr = 0;
  endtask

  task automatic shift_upd(input logic [17:0] din, output logic [17:0] dout);
    for (int i = 0; i < 18; i++) begin
      dout[i] = tdo; tdi = din[i]; shift_dr = 1;
      tick(1);
    end
    shift_dr = 0; update_dr = 1; tick(1); update_dr = 0;
  endtask

  task automatic scan(input logic [17:0] din, output logic [17:0] dout);
    cap_pulse();
    shift_upd(din, dout);
  endtask

  task automatic addr_set(input logic [15:0] a);
    addr_in = a; addr_load = 1; tick(1); addr_load = 0; tick(20);
  endtask

  logic [17:0] d;

  initial begin
    tick(3);
    chk("R11 busy", busy, 0);
    chk("R11 prog_err", prog_err, 0);
    chk("R11 fl_req", fl_req, 0);
    chk("R11 tdo", tdo, 0);
    trst_n = 1; tick(2);

    sel_rd = 1;
    scan(18'h0, d);
    chk("R11 first capture valid", d[16], 0);
    tick(2);
    chk("R4 no access after empty capture", fl_req, 0);

    sel_rd = 0; sel_wr = 1;
    addr_set(16'h0040);
    for (int k = 0; k < 6; k++) begin
      scan({2'b01, VEC[k]}, d);
      chk("R7 busy after update", busy, 1);
      chk("R8 captured status", d[17:16], 2'b01);
      chk("R8 captured data", d[15:0], (k == 0) ? initv(16'h0040) : VEC[k-1]);
      tick(20);
      chk("R7 busy cleared", busy, 0);
    end
    scan(18'h0, d);
    chk("R8 last read-back", d, {2'b01, VEC[5]});

    sel_wr = 0; sel_rd = 1;
    addr_set(16'h0040);
    for (int k = 0; k < 6; k++) begin
      scan(18'h0, d);
      chk("R3 read word", d, {2'b01, VEC[k]});
      tick(10);
    end

    addr_set(16'h0040);
    capture_dr = 1;
    @(posedge tck); #1;
    chk("R1 tdo held at rising edge", tdo, 0);
    @(negedge tck); #1;
    chk("R1 tdo at falling edge", tdo, 1);
    capture_dr = 0;
    shift_upd(18'h0, d);
    tick(10);

    addr_in = 16'h0044; addr_load = 1; tick(1); addr_load = 0;
    while (!fl_ack) tick(0);
    cap_pulse();
    shift_upd(18'h0, d);
    chk("R12 collided capture valid", d[16], 0);
    tick(5);
    scan(18'h0, d);
    chk("R12 word kept", d, {2'b01, VEC[2]});
    tick(10);
    scan(18'h0, d);
    chk("R12 single step", d, {2'b01, VEC[3]});

    lat = 30;
    addr_set(16'h0040); tick(20);
    scan(18'h0, d);
    chk("R3 slow first", d, {2'b01, VEC[0]});
    scan(18'h0, d);
    chk("R4 pending valid", d[16], 0);
    tick(40);
    scan(18'h0, d);
    chk("R4 no double step", d, {2'b01, VEC[1]});
    lat = 3; tick(40);

    sel_rd = 0; sel_wr = 1;
    addr_set(16'h0050);
    shift_upd({2'b01, 16'h1234}, d);
    chk("R6 valid set blocks write", busy, 0);
    chk("R6 no request", fl_req, 0);
    scan({2'b00, 16'h9999}, d);
    chk("R6 bit16 clear blocks write", busy, 0);
    tick(10);
    sel_wr = 0; sel_rd = 1;
    addr_set(16'h0050);
    scan(18'h0, d);
    chk("R6 flash untouched", d, {2'b01, initv(16'h0050)});
    tick(10);

    sel_rd = 0; sel_wr = 1;
    addr_set(16'h0060);
    xmask = 16'h0004;
    scan({2'b01, 16'h00F0}, d);
    tick(20);
    xmask = 0;
    scan(18'h0, d);
    chk("R8 mismatch error", d, {2'b11, 16'h00F4});
    chk("R9 prog_err set", prog_err, 1);
    scan({2'b01, 16'h0101}, d);
    tick(20);
    scan(18'h0, d);
    chk("R8 good write", d, {2'b01, 16'h0101});
    chk("R9 prog_err sticky", prog_err, 1);

    sel_wr = 0; sel_rd = 1;
    inj_err = 1;
    addr_set(16'h0070);
    inj_err = 0;
    scan(18'h0, d);
    chk("R3 flash error reported", d[17:16], 2'b11);
    tick(10);
    scan(18'h0, d);
    chk("R3 error clears", d[17:16], 2'b01);
    chk("R10 address load then step", d[15:0], initv(16'h0072));

    trst_n = 0; tick(1);
    chk("R9 cleared by reset", prog_err, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule